// File: doc/BRIEF.md
# G.711 Companding Encoder and Decoder

This block converts between linear two's-complement PCM samples and 8-bit companded G.711 codes, in both directions at once. A static law input selects A-law or mu-law. The encoder path takes a linear sample and returns the 8-bit code already in line format. The decoder path takes a line-format code and returns the linear sample. The codes can therefore move directly to or from a serial PCM transport with no further bit manipulation.

Each path has its own valid strobe and one register stage. An output appears on the cycle after its input was marked valid, and it holds its last value while no new input arrives. Both laws share one 14-bit linear port. A-law uses the 13-bit range on that port (-4096..4095, sign-extended). Mu-law uses the full 14 bits.

Top module: `g711_codec`

## Requirements
- R1: `law_mu` = 0 selects A-law and `law_mu` = 1 selects mu-law, for both paths, on the cycle the input is marked valid. A decoded A-law sample always lies in -4096..4095.
- R2: Bit 7 of every code is the polarity, 1 for zero and positive samples and 0 for negative samples. The decoder returns a non-negative sample for bit 7 = 1 and a negative sample for bit 7 = 0.
- R3: A-law line code = {polarity, segment[2:0], step[3:0]} XOR 8'h55. Sample 0 gives 8'hD5, sample -1 gives 8'h55, sample 4095 gives 8'hAA and sample -4096 gives 8'h2A.
- R4: Mu-law line code = {polarity, ~segment, ~step}, so every bit except the polarity is inverted. Sample 0 gives 8'hFF, sample -1 gives 8'h7F, sample 8158 gives 8'h80 and sample -8159 gives 8'h00.
- R5: Magnitudes that are too large saturate to the full-scale code of the same sign. A-law: samples above 4095 give 8'hAA and samples below -4096 give 8'h2A. Mu-law: samples above 8158 give 8'h80 and samples below -8159 give 8'h00.
- R6: A-law quantisation works on a magnitude m, where m = x for x >= 0 and m = -x-1 for x < 0. For m < 32: segment 0 and step m>>1. Otherwise the segment s satisfies 16<<s <= m < 32<<s, and the step is (m>>s) mod 16.
- R7: Mu-law quantisation works on b = m + 33, with m formed as in R6. The segment s is the smallest value with b < 64<<s, and the step is (b>>(s+1)) mod 16.
- R8: The A-law decoder returns magnitude 2q+1 for segment 0 and (2q+33)<<(s-1) for segment s >= 1. Here q is the step and s the segment after the XOR with 8'h55.
- R9: The mu-law decoder returns magnitude ((2q+33)<<s) - 33, with q and s taken after the inversion. In both laws a negative code returns -magnitude-1.
- R10: For each law and each of the 256 codes, encoding the decoded sample gives back the same code.
- R11: An output valid rises exactly one cycle after its input valid. While the input valid is low, the output valid is low and the output data holds its last value.
- R12: During reset both output valids are 0, the code output is 8'h00 and the sample output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| law_mu | input | 1 | 0 = A-law, 1 = mu-law |
| enc_in_valid | input | 1 | Encoder input sample is valid |
| enc_in_sample | input | 14 | Linear two's-complement sample to encode |
| dec_in_valid | input | 1 | Decoder input code is valid |
| dec_in_code | input | 8 | Line-format code to decode |
| enc_out_valid | output | 1 | Encoder result is valid |
| enc_out_code | output | 8 | Line-format code |
| dec_out_valid | output | 1 | Decoder result is valid |
| dec_out_sample | output | 14 | Decoded linear sample |

## Verification
The bench covers all 256 codes in both laws and feeds each decoded value back through the encoder. A negative-magnitude rule that uses -x instead of -x-1 breaks the round trip at the -0 code and shifts every negative step. The bench drives samples at segment edges: A-law 31/32 and mu-law 30/31, where the +33 bias moves the value into the next segment. A missing bias, or a wrong shift for A-law segment 0, shows up there as the wrong step. The bench also drives samples beyond full scale, including -8192. A design without saturation would wrap those into small codes or flip the polarity of the code. A design that leaves out the A-law even-bit XOR, or the mu-law inversion, fails every full-scale and zero anchor code.

// File: rtl/g711_pkg.sv
package g711_pkg;
    localparam int LIN_W     = 14;
    localparam int MAG_W     = LIN_W - 1;
    localparam int CODE_W    = 8;
    localparam int SEG_W     = 3;
    localparam int STEP_W    = 4;
    localparam int IDX_W     = $clog2(MAG_W);
    localparam logic [MAG_W-1:0] A_MAX_MAG  = MAG_W'(4095);
    localparam logic [MAG_W-1:0] MU_MAX_MAG = MAG_W'(8158);
    localparam logic [MAG_W-1:0] MU_BIAS    = MAG_W'(33);
    localparam logic [SEG_W-1:0]  A_SEG_FLIP  = 3'b101;
    localparam logic [STEP_W-1:0] A_STEP_FLIP = 4'b0101;

    typedef struct packed {
        logic              pos;
        logic [SEG_W-1:0]  seg;
        logic [STEP_W-1:0] step;
    } code_t;
endpackage

// File: rtl/g711_lead_one.sv
module g711_lead_one #(
    parameter int W     = 13,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx
);
    // highest set bit; zero when vec is zero
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/g711_enc_core.sv
module g711_enc_core
    import g711_pkg::*;
(
    input  logic              law_mu,
    input  logic [LIN_W-1:0]  sample,
    output logic [CODE_W-1:0] code
);
    logic             pos;
    logic [MAG_W-1:0] mag_raw;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] lim;
    logic [MAG_W-1:0] val;
    logic [IDX_W-1:0] msb;
    logic [SEG_W-1:0] seg;
    logic [3:0]       shamt;
    logic [MAG_W-1:0] shifted;
    code_t            raw;

    always_comb begin
        pos     = ~sample[LIN_W-1];
        // one's-complement magnitude keeps -0 distinct from +0
        mag_raw = pos ? sample[MAG_W-1:0] : ~sample[MAG_W-1:0];
        lim     = law_mu ? MU_MAX_MAG : A_MAX_MAG;
        mag     = (mag_raw > lim) ? lim : mag_raw;
        val     = law_mu ? (mag + MU_BIAS) : mag;
    end

    g711_lead_one #(.W(MAG_W), .IDX_W(IDX_W)) u_lod (
        .vec (val),
        .idx (msb)
    );

    always_comb begin
        if (law_mu) begin
            seg   = (val < MAG_W'(64)) ? '0 : SEG_W'(msb - IDX_W'(5));
            shamt = 4'(seg) + 4'd1;
        end else begin
            seg   = (val < MAG_W'(32)) ? '0 : SEG_W'(msb - IDX_W'(4));
            shamt = (seg == '0) ? 4'd1 : 4'(seg);
        end
        shifted  = val >> shamt;
        raw.pos  = pos;
        raw.seg  = seg;
        raw.step = shifted[STEP_W-1:0];
        if (law_mu) code = {raw.pos, ~raw.seg, ~raw.step};
        else        code = {raw.pos, raw.seg ^ A_SEG_FLIP, raw.step ^ A_STEP_FLIP};
    end
endmodule

// File: rtl/g711_dec_core.sv
module g711_dec_core
    import g711_pkg::*;
(
    input  logic              law_mu,
    input  logic [CODE_W-1:0] code,
    output logic [LIN_W-1:0]  sample
);
    code_t            raw;
    logic [MAG_W-1:0] odd;
    logic [MAG_W-1:0] base;
    logic [MAG_W-1:0] mag;

    always_comb begin
        raw.pos = code[CODE_W-1];
        if (law_mu) begin
            raw.seg  = ~code[6:4];
            raw.step = ~code[3:0];
        end else begin
            raw.seg  = code[6:4] ^ A_SEG_FLIP;
            raw.step = code[3:0] ^ A_STEP_FLIP;
        end
        odd  = MAG_W'({raw.step, 1'b1});
        base = odd + MAG_W'(32);
        if (law_mu)              mag = (base << raw.seg) - MU_BIAS;
        else if (raw.seg == '0)  mag = odd;
        else                     mag = base << (raw.seg - SEG_W'(1));
        sample = raw.pos ? {1'b0, mag} : ~{1'b0, mag};
    end
endmodule

// File: rtl/g711_codec.sv
module g711_codec
    import g711_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              law_mu,
    input  logic              enc_in_valid,
    input  logic [LIN_W-1:0]  enc_in_sample,
    input  logic              dec_in_valid,
    input  logic [CODE_W-1:0] dec_in_code,
    output logic              enc_out_valid,
    output logic [CODE_W-1:0] enc_out_code,
    output logic              dec_out_valid,
    output logic [LIN_W-1:0]  dec_out_sample
);
    typedef struct packed {
        logic              enc_vld;
        logic [CODE_W-1:0] enc_code;
        logic              dec_vld;
        logic [LIN_W-1:0]  dec_sample;
    } state_t;

    state_t            st_d, st_q;
    logic [CODE_W-1:0] enc_code_c;
    logic [LIN_W-1:0]  dec_sample_c;

    g711_enc_core u_enc (
        .law_mu (law_mu),
        .sample (enc_in_sample),
        .code   (enc_code_c)
    );

    g711_dec_core u_dec (
        .law_mu (law_mu),
        .code   (dec_in_code),
        .sample (dec_sample_c)
    );

    always_comb begin
        st_d         = st_q;
        st_d.enc_vld = enc_in_valid;
        st_d.dec_vld = dec_in_valid;
        if (enc_in_valid) st_d.enc_code   = enc_code_c;
        if (dec_in_valid) st_d.dec_sample = dec_sample_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enc_out_valid  = st_q.enc_vld;
    assign enc_out_code   = st_q.enc_code;
    assign dec_out_valid  = st_q.dec_vld;
    assign dec_out_sample = st_q.dec_sample;

    AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid |=> enc_out_valid); // R11
    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_in_valid |=> (!enc_out_valid && $stable(enc_out_code))); // R11
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_in_valid |=> (!dec_out_valid && $stable(dec_out_sample))); // R11
    AST_ENC_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid |=> (enc_out_code[7] == !$past(enc_in_sample[LIN_W-1]))); // R2
    AST_DEC_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid |=> (dec_out_sample[LIN_W-1] == !$past(dec_in_code[7]))); // R2
    AST_A_DEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_in_valid && !law_mu) |=> (dec_out_sample[13] == dec_out_sample[12])); // R1
    AST_A_POS_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_in_valid && !law_mu && !enc_in_sample[13] && enc_in_sample[12])
        |=> (enc_out_code == 8'hAA)); // R5
    AST_A_NEG_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_in_valid && !law_mu && enc_in_sample[13] && !enc_in_sample[12])
        |=> (enc_out_code == 8'h2A)); // R5
    AST_MU_POS_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_in_valid && law_mu && !enc_in_sample[13] && (enc_in_sample > 14'd8158))
        |=> (enc_out_code == 8'h80)); // R5
endmodule

// File: tb/tb_g711_codec.sv
module tb_g711_codec;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } enc_item_t;
    typedef struct {
        logic [13:0] exp;
        string       tag;
    } dec_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        law_mu = 1'b0;
    logic        enc_in_valid = 1'b0;
    logic [13:0] enc_in_sample = '0;
    logic        dec_in_valid = 1'b0;
    logic [7:0]  dec_in_code = '0;
    logic        enc_out_valid;
    logic [7:0]  enc_out_code;
    logic        dec_out_valid;
    logic [13:0] dec_out_sample;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    enc_item_t enc_q[$];
    dec_item_t dec_q[$];

    g711_codec dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .law_mu         (law_mu),
        .enc_in_valid   (enc_in_valid),
        .enc_in_sample  (enc_in_sample),
        .dec_in_valid   (dec_in_valid),
        .dec_in_code    (dec_in_code),
        .enc_out_valid  (enc_out_valid),
        .enc_out_code   (enc_out_code),
        .dec_out_valid  (dec_out_valid),
        .dec_out_sample (dec_out_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference models written from R3..R9
    function automatic logic [7:0] ref_enc(input bit mu, input int x);
        int m, s, q, b;
        bit p;
        p = (x >= 0);
        m = p ? x : -x - 1;
        if (!mu) begin
            if (m > 4095) m = 4095;
            if (m < 32) begin s = 0; q = m / 2; end
            else begin
                s = 1;
                while (m >= (32 << s)) s++;
                q = (m >> s) % 16;
            end
            return 8'(((p ? 1 : 0) << 7) | (s << 4) | q) ^ 8'h55;
        end
        if (m > 8158) m = 8158;
        b = m + 33;
        s = 0;
        while (b >= (64 << s)) s++;
        q = (b >> (s + 1)) % 16;
        return 8'(((p ? 0 : 1) << 7) | (s << 4) | q) ^ 8'hFF;
    endfunction

    function automatic int ref_dec(input bit mu, input logic [7:0] c);
        logic [7:0] t;
        int s, q, m;
        t = mu ? (c ^ 8'hFF) : (c ^ 8'h55);
        s = int'(t[6:4]);
        q = int'(t[3:0]);
        if (mu)          m = ((2*q + 33) << s) - 33;
        else if (s == 0) m = 2*q + 1;
        else             m = (2*q + 33) << (s - 1);
        return c[7] ? m : -m - 1;
    endfunction

    task automatic push_enc(input bit mu, input int x, input logic [7:0] exp, input string tag);
        @(negedge clk);
        law_mu        = mu;
        enc_in_valid  = 1'b1;
        enc_in_sample = x[13:0];
        dec_in_valid  = 1'b0;
        enc_q.push_back('{exp: exp, tag: tag});
    endtask

    task automatic push_both(input bit mu, input logic [7:0] c);
        int v;
        v = ref_dec(mu, c);
        @(negedge clk);
        law_mu        = mu;
        dec_in_valid  = 1'b1;
        dec_in_code   = c;
        enc_in_valid  = 1'b1;
        enc_in_sample = v[13:0];
        dec_q.push_back('{exp: v[13:0], tag: mu ? "R9 mu decode" : "R8 A decode"});
        enc_q.push_back('{exp: c, tag: "R10 round trip"});
    endtask

    task automatic go_idle();
        @(negedge clk);
        enc_in_valid = 1'b0;
        dec_in_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && enc_out_valid) begin
            if (enc_q.size() == 0) check(1'b0, "R11 unexpected encoder output", 1, 0);
            else begin
                enc_item_t it;
                it = enc_q.pop_front();
                check(enc_out_code == it.exp, it.tag, int'(enc_out_code), int'(it.exp));
            end
        end
        if (rst_n && dec_out_valid) begin
            if (dec_q.size() == 0) check(1'b0, "R11 unexpected decoder output", 1, 0);
            else begin
                dec_item_t it;
                it = dec_q.pop_front();
                check(dec_out_sample == it.exp, it.tag,
                      int'($signed(dec_out_sample)), int'($signed(it.exp)));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(enc_out_valid == 1'b0 && dec_out_valid == 1'b0, "R12 reset valids",
              int'({enc_out_valid, dec_out_valid}), 0);
        check(enc_out_code == 8'h00, "R12 reset code", int'(enc_out_code), 0);
        check(dec_out_sample == 14'd0, "R12 reset sample", int'(dec_out_sample), 0);
        rst_n = 1'b1;

        // R3 A-law anchors
        push_enc(1'b0, 0,     8'hD5, "R3 A +0");
        push_enc(1'b0, -1,    8'h55, "R3 A -0");
        push_enc(1'b0, 4095,  8'hAA, "R3 A +full");
        push_enc(1'b0, -4096, 8'h2A, "R3 A -full");
        // R4 mu-law anchors
        push_enc(1'b1, 0,     8'hFF, "R4 mu +0");
        push_enc(1'b1, -1,    8'h7F, "R4 mu -0");
        push_enc(1'b1, 8158,  8'h80, "R4 mu +full");
        push_enc(1'b1, -8159, 8'h00, "R4 mu -full");
        // R5 saturation
        push_enc(1'b0, 5000,  8'hAA, "R5 A clip pos");
        push_enc(1'b0, 8191,  8'hAA, "R5 A clip pos max");
        push_enc(1'b0, -4097, 8'h2A, "R5 A clip neg");
        push_enc(1'b0, -8192, 8'h2A, "R5 A clip neg min");
        push_enc(1'b1, 8159,  8'h80, "R5 mu clip pos");
        push_enc(1'b1, 8191,  8'h80, "R5 mu clip pos max");
        push_enc(1'b1, -8160, 8'h00, "R5 mu clip neg");
        push_enc(1'b1, -8192, 8'h00, "R5 mu clip neg min");
        // R6 A-law segment edges, R2 polarity
        push_enc(1'b0, 31,  8'hDA, "R6 A seg0 top");
        push_enc(1'b0, 32,  8'hC5, "R6 A seg1 bottom");
        push_enc(1'b0, 100, 8'hFC, "R6 A seg2");
        push_enc(1'b0, -33, 8'h45, "R2 R6 A negative seg1");
        // R7 mu-law bias edge
        push_enc(1'b1, 30, 8'hF0, "R7 mu seg0 top");
        push_enc(1'b1, 31, 8'hEF, "R7 mu bias into seg1");
        // R1 sweep in both laws
        for (int x = -8192; x < 8192; x += 97) begin
            push_enc(1'b0, x, ref_enc(1'b0, x), "R1 R6 A sweep");
            push_enc(1'b1, x, ref_enc(1'b1, x), "R1 R7 mu sweep");
        end
        // R8 R9 R10 every code in both laws
        for (int mu = 0; mu < 2; mu++) begin
            for (int c = 0; c < 256; c++) push_both(mu[0], c[7:0]);
        end
        // R11 hold: last pushes were mu code 8'hFF
        go_idle();
        @(negedge clk);
        enc_in_sample = 14'h1234;
        dec_in_code   = 8'h12;
        law_mu        = 1'b0;
        repeat (3) @(negedge clk);
        check(enc_out_valid == 1'b0 && dec_out_valid == 1'b0, "R11 valids low when idle",
              int'({enc_out_valid, dec_out_valid}), 0);
        check(enc_out_code == 8'hFF, "R11 code held", int'(enc_out_code), 255);
        check(dec_out_sample == 14'd0, "R11 sample held", int'(dec_out_sample), 0);
        check(enc_q.size() == 0 && dec_q.size() == 0, "R11 all results seen",
              enc_q.size() + dec_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule